// File: doc/BRIEF.md
# Segment Base-Limit Address Translator

This block turns a logical address, given as a segment number and a displacement, into a physical address. It holds one entry per segment in a small register file. Each entry has a base address, a limit (the segment's size) and a valid bit. A privileged controller loads entries through a write port. The same controller also sets a table-length register, which says how many segment numbers are currently in use.

A lookup reads the entry combinationally and checks that the segment is defined. It then checks the displacement against the limit. If every check passes, a full-width adder forms base plus displacement, and the block flags an error if that sum does not fit the physical address width. The response is registered: one cycle after a request, the block presents a valid strobe together with either the physical address or an error flag. A requester uses the error to trap instead of reaching memory.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset, every entry is invalid, the table length is 0 and all response outputs are 0. Any request made before the table is loaded returns an error.
- R2: `rsp_valid_o` is high in the cycle that follows each cycle in which `req_valid_i` is high.
- R3: When every check passes, `rsp_addr_o` equals the entry's base plus the zero-extended displacement and `rsp_err_o` is 0. For example, segment 3 with limit 2000 and base 3500, requested with displacement 1123, gives 4623.
- R4: A displacement greater than or equal to the entry's limit gives an error. A displacement equal to the limit is out of bounds; limit minus one is accepted.
- R5: A request to an entry whose valid bit is 0 gives an error. An entry written with `wr_vld_i` = 0 becomes invalid.
- R6: A segment number greater than or equal to the table length gives an error, even if the entry is valid.
- R7: If base plus displacement exceeds 2^PA_W - 1, the result is an error. The largest representable sum is still accepted.
- R8: A table write takes effect from the next cycle. A lookup to the entry being written in the same cycle sees the old base, limit and valid bit.
- R9: A table-length write takes effect from the next cycle. A lookup in the same cycle as the write uses the old length.
- R10: When `rsp_err_o` is 1, `rsp_addr_o` is 0.
- R11: In a cycle after no request, `rsp_valid_o`, `rsp_err_o` and `rsp_addr_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write one table entry |
| wr_seg_i | input | SEG_W | Index of the entry to write |
| wr_vld_i | input | 1 | Valid bit to store |
| wr_limit_i | input | DISP_W | Segment size to store |
| wr_base_i | input | PA_W | Segment base to store |
| len_we_i | input | 1 | Write the table-length register |
| len_i | input | SEG_W+1 | New table length (number of usable segments) |
| req_valid_i | input | 1 | Lookup request strobe |
| req_seg_i | input | SEG_W | Requested segment number |
| req_disp_i | input | DISP_W | Requested displacement |
| rsp_valid_o | output | 1 | Response strobe, one cycle after request |
| rsp_addr_o | output | PA_W | Physical address, 0 on error |
| rsp_err_o | output | 1 | Translation fault |

## Verification
The assertions assume that the controller does not write to the table while it reads the response of a lookup it has just issued. The bench never does this, except in the deliberate same-cycle collision cases. The assertions also assume that `len_i` never exceeds the number of entries. The bench only writes lengths between 0 and 8. They further assume DISP_W ≤ PA_W, so that the displacement can always be zero-extended into the sum. Every request is driven for exactly one cycle. Overflow cases are built from a base near the top of the address space, so that the sum crosses 2^PA_W exactly at the tested boundary.

// File: rtl/seg_xlate_pkg.sv
`timescale 1ns/1ps
package seg_xlate_pkg;
  // fault causes, in check priority order
  typedef enum logic [2:0] {
    FLT_NONE     = 3'd0,
    FLT_UNDEF    = 3'd1,
    FLT_RANGE    = 3'd2,
    FLT_BOUND    = 3'd3,
    FLT_WRAP     = 3'd4
  } seg_fault_e;
endpackage

// File: rtl/seg_table.sv
`timescale 1ns/1ps
module seg_table #(
  parameter int SEG_W  = 3,
  parameter int DISP_W = 12,
  parameter int PA_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SEG_W-1:0]  wr_seg_i,
  input  logic              wr_vld_i,
  input  logic [DISP_W-1:0] wr_limit_i,
  input  logic [PA_W-1:0]   wr_base_i,
  input  logic              len_we_i,
  input  logic [SEG_W:0]    len_i,
  input  logic [SEG_W-1:0]  rd_seg_i,
  output logic              rd_vld_o,
  output logic [DISP_W-1:0] rd_limit_o,
  output logic [PA_W-1:0]   rd_base_o,
  output logic              rd_in_len_o
);
  localparam int NSEG  = 1 << SEG_W;
  localparam int LEN_W = SEG_W + 1;

  logic              vld_q   [NSEG];
  logic [DISP_W-1:0] limit_q [NSEG];
  logic [PA_W-1:0]   base_q  [NSEG];
  logic [LEN_W-1:0]  len_q;
  logic [NSEG-1:0]   ent_we;

  for (genvar g = 0; g < NSEG; g++) begin : g_dec
    assign ent_we[g] = wr_en_i && (wr_seg_i == SEG_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NSEG; i++) begin
        vld_q[i]   <= 1'b0;
        limit_q[i] <= '0;
        base_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NSEG; i++) begin
        if (ent_we[i]) begin
          vld_q[i]   <= wr_vld_i;
          limit_q[i] <= wr_limit_i;
          base_q[i]  <= wr_base_i;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       len_q <= '0;
    else if (len_we_i) len_q <= len_i;
  end

  // read sees register state only: same-cycle writes are not forwarded
  assign rd_vld_o    = vld_q[rd_seg_i];
  assign rd_limit_o  = limit_q[rd_seg_i];
  assign rd_base_o   = base_q[rd_seg_i];
  assign rd_in_len_o = {1'b0, rd_seg_i} < len_q;

  // R8: written entry holds new contents on the following cycle
  a_r8_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (base_q[$past(wr_seg_i)] == $past(wr_base_i)) &&
                (limit_q[$past(wr_seg_i)] == $past(wr_limit_i)) &&
                (vld_q[$past(wr_seg_i)] == $past(wr_vld_i)));

  // R9: length write visible next cycle
  a_r9_len_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_we_i |=> len_q == $past(len_i));
endmodule

// File: rtl/seg_check.sv
`timescale 1ns/1ps
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int DISP_W = 12,
  parameter int PA_W   = 16
) (
  input  logic              ent_vld_i,
  input  logic              ent_in_len_i,
  input  logic [DISP_W-1:0] ent_limit_i,
  input  logic [PA_W-1:0]   ent_base_i,
  input  logic [DISP_W-1:0] disp_i,
  output seg_fault_e        fault_o,
  output logic [PA_W-1:0]   paddr_o
);
  localparam int SUM_W = PA_W + 1;
  localparam int PAD_W = SUM_W - DISP_W;

  logic [SUM_W-1:0] sum;
  logic             in_bound;
  logic             wrap;

  assign sum      = {1'b0, ent_base_i} + {{PAD_W{1'b0}}, disp_i};
  assign in_bound = disp_i < ent_limit_i;
  assign wrap     = sum[PA_W];
  assign paddr_o  = sum[PA_W-1:0];

  always_comb begin
    if (!ent_vld_i)         fault_o = FLT_UNDEF;
    else if (!ent_in_len_i) fault_o = FLT_RANGE;
    else if (!in_bound)     fault_o = FLT_BOUND;
    else if (wrap)          fault_o = FLT_WRAP;
    else                    fault_o = FLT_NONE;
  end
endmodule

// File: rtl/seg_rsp_stage.sv
`timescale 1ns/1ps
module seg_rsp_stage
  import seg_xlate_pkg::*;
#(
  parameter int PA_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  seg_fault_e      fault_i,
  input  logic [PA_W-1:0] paddr_i,
  output logic            rsp_valid_o,
  output logic [PA_W-1:0] rsp_addr_o,
  output logic            rsp_err_o
);
  logic bad;
  assign bad = fault_i != FLT_NONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_addr_o  <= '0;
      rsp_err_o   <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_err_o   <= req_valid_i && bad;
      rsp_addr_o  <= (req_valid_i && !bad) ? paddr_i : '0;
    end
  end

  // R10: a faulting response never exposes an address
  a_r10_err_no_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> rsp_valid_o && rsp_addr_o == '0);
endmodule

// File: rtl/seg_xlate_unit.sv
`timescale 1ns/1ps
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W  = 3,
  parameter int DISP_W = 12,
  parameter int PA_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SEG_W-1:0]  wr_seg_i,
  input  logic              wr_vld_i,
  input  logic [DISP_W-1:0] wr_limit_i,
  input  logic [PA_W-1:0]   wr_base_i,
  input  logic              len_we_i,
  input  logic [SEG_W:0]    len_i,
  input  logic              req_valid_i,
  input  logic [SEG_W-1:0]  req_seg_i,
  input  logic [DISP_W-1:0] req_disp_i,
  output logic              rsp_valid_o,
  output logic [PA_W-1:0]   rsp_addr_o,
  output logic              rsp_err_o
);
  logic              rd_vld;
  logic [DISP_W-1:0] rd_limit;
  logic [PA_W-1:0]   rd_base;
  logic              rd_in_len;
  seg_fault_e        fault;
  logic [PA_W-1:0]   paddr;

  seg_table #(.SEG_W(SEG_W), .DISP_W(DISP_W), .PA_W(PA_W)) u_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_seg_i    (wr_seg_i),
    .wr_vld_i    (wr_vld_i),
    .wr_limit_i  (wr_limit_i),
    .wr_base_i   (wr_base_i),
    .len_we_i    (len_we_i),
    .len_i       (len_i),
    .rd_seg_i    (req_seg_i),
    .rd_vld_o    (rd_vld),
    .rd_limit_o  (rd_limit),
    .rd_base_o   (rd_base),
    .rd_in_len_o (rd_in_len)
  );

  seg_check #(.DISP_W(DISP_W), .PA_W(PA_W)) u_check (
    .ent_vld_i    (rd_vld),
    .ent_in_len_i (rd_in_len),
    .ent_limit_i  (rd_limit),
    .ent_base_i   (rd_base),
    .disp_i       (req_disp_i),
    .fault_o      (fault),
    .paddr_o      (paddr)
  );

  seg_rsp_stage #(.PA_W(PA_W)) u_rsp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .fault_i     (fault),
    .paddr_i     (paddr),
    .rsp_valid_o (rsp_valid_o),
    .rsp_addr_o  (rsp_addr_o),
    .rsp_err_o   (rsp_err_o)
  );

  // reference sum for the properties below
  logic [PA_W:0] ref_sum;
  assign ref_sum = {1'b0, rd_base} + (PA_W+1)'(req_disp_i);

  // R2
  a_r2_rsp_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  // R11
  a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o && !rsp_err_o && rsp_addr_o == '0);
  // R4
  a_r4_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_disp_i >= rd_limit) |=> rsp_err_o);
  // R5
  a_r5_undef: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !rd_vld) |=> rsp_err_o);
  // R6
  a_r6_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !rd_in_len) |=> rsp_err_o);
  // R7
  a_r7_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && ref_sum[PA_W]) |=> rsp_err_o);
  // R3
  a_r3_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && rd_vld && rd_in_len && req_disp_i < rd_limit && !ref_sum[PA_W])
      |=> !rsp_err_o && rsp_addr_o == $past(ref_sum[PA_W-1:0]));
endmodule

// File: tb/seg_xlate_unit_test.sv
`timescale 1ns/1ps
module seg_xlate_unit_test;
  localparam int SEG_W  = 3;
  localparam int DISP_W = 12;
  localparam int PA_W   = 16;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_en_i = 1'b0;
  logic [SEG_W-1:0]  wr_seg_i = '0;
  logic              wr_vld_i = 1'b0;
  logic [DISP_W-1:0] wr_limit_i = '0;
  logic [PA_W-1:0]   wr_base_i = '0;
  logic              len_we_i = 1'b0;
  logic [SEG_W:0]    len_i = '0;
  logic              req_valid_i = 1'b0;
  logic [SEG_W-1:0]  req_seg_i = '0;
  logic [DISP_W-1:0] req_disp_i = '0;
  logic              rsp_valid_o;
  logic [PA_W-1:0]   rsp_addr_o;
  logic              rsp_err_o;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  seg_xlate_unit #(.SEG_W(SEG_W), .DISP_W(DISP_W), .PA_W(PA_W)) uut (.*);

  task automatic chk(string req, string what, int got, int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic put_entry(int seg, bit vld, int limit, int base);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_seg_i = SEG_W'(seg); wr_vld_i = vld;
    wr_limit_i = DISP_W'(limit); wr_base_i = PA_W'(base);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic put_len(int len);
    @(negedge clk_i);
    len_we_i = 1'b1; len_i = (SEG_W+1)'(len);
    @(negedge clk_i);
    len_we_i = 1'b0;
  endtask

  // one request; expects ok address, or error with address 0
  task automatic lookup(string req, int seg, int disp, bit exp_err, int exp_addr);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_seg_i = SEG_W'(seg); req_disp_i = DISP_W'(disp);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(req, "rsp_valid", int'(rsp_valid_o), 1);
    chk(req, "rsp_err", int'(rsp_err_o), int'(exp_err));
    chk(req, "rsp_addr", int'(rsp_addr_o), exp_err ? 0 : exp_addr);
  endtask

  task automatic t_reset();
    chk("R1", "valid after reset", int'(rsp_valid_o), 0);
    chk("R1", "addr after reset", int'(rsp_addr_o), 0);
    chk("R1", "err after reset", int'(rsp_err_o), 0);
    lookup("R1", 0, 0, 1'b1, 0);
    lookup("R1", 7, 5, 1'b1, 0);
  endtask

  task automatic t_load();
    put_len(8);
    put_entry(0, 1'b1, 1500, 1000);
    put_entry(1, 1'b1, 200, 5500);
    put_entry(2, 1'b1, 700, 6000);
    put_entry(3, 1'b1, 2000, 3500);
  endtask

  task automatic t_basic();
    lookup("R3", 3, 1123, 1'b0, 4623);
    lookup("R3", 0, 0, 1'b0, 1000);
    lookup("R3", 1, 199, 1'b0, 5699);
    lookup("R3", 2, 5, 1'b0, 6005);
  endtask

  task automatic t_bound();
    lookup("R4", 3, 2000, 1'b1, 0);
    lookup("R4", 3, 1999, 1'b0, 5499);
    lookup("R4", 1, 4095, 1'b1, 0);
    lookup("R10", 2, 700, 1'b1, 0);
  endtask

  task automatic t_undef();
    lookup("R5", 5, 0, 1'b1, 0);
    put_entry(4, 1'b1, 100, 200);
    lookup("R5", 4, 10, 1'b0, 210);
    put_entry(4, 1'b0, 100, 200);
    lookup("R5", 4, 10, 1'b1, 0);
  endtask

  task automatic t_length();
    put_len(3);
    lookup("R6", 3, 0, 1'b1, 0);
    lookup("R6", 2, 0, 1'b0, 6000);
    put_len(0);
    lookup("R6", 0, 0, 1'b1, 0);
    put_len(8);
    lookup("R6", 3, 0, 1'b0, 3500);
  endtask

  task automatic t_wrap();
    put_entry(6, 1'b1, 4000, 65000);
    lookup("R7", 6, 535, 1'b0, 65535);
    lookup("R7", 6, 536, 1'b1, 0);
    lookup("R7", 6, 3999, 1'b1, 0);
  endtask

  task automatic t_strobe();
    @(negedge clk_i);
    req_valid_i = 1'b1; req_seg_i = 3'd0; req_disp_i = 12'd7;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk("R2", "valid one cycle later", int'(rsp_valid_o), 1);
    chk("R2", "addr", int'(rsp_addr_o), 1007);
    @(negedge clk_i);
    chk("R11", "valid idle", int'(rsp_valid_o), 0);
    chk("R11", "addr idle", int'(rsp_addr_o), 0);
    chk("R11", "err idle", int'(rsp_err_o), 0);
  endtask

  task automatic t_wr_collide();
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_seg_i = 3'd2; wr_vld_i = 1'b1;
    wr_limit_i = 12'd50; wr_base_i = 16'd9000;
    req_valid_i = 1'b1; req_seg_i = 3'd2; req_disp_i = 12'd100;
    @(negedge clk_i);
    wr_en_i = 1'b0; req_valid_i = 1'b0;
    chk("R8", "old entry err", int'(rsp_err_o), 0);
    chk("R8", "old entry addr", int'(rsp_addr_o), 6100);
    lookup("R8", 2, 100, 1'b1, 0);
    lookup("R8", 2, 49, 1'b0, 9049);
  endtask

  task automatic t_len_collide();
    @(negedge clk_i);
    len_we_i = 1'b1; len_i = 4'd2;
    req_valid_i = 1'b1; req_seg_i = 3'd3; req_disp_i = 12'd1;
    @(negedge clk_i);
    len_we_i = 1'b0; req_valid_i = 1'b0;
    chk("R9", "old length err", int'(rsp_err_o), 0);
    chk("R9", "old length addr", int'(rsp_addr_o), 3501);
    lookup("R9", 3, 1, 1'b1, 0);
    put_len(8);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_load();
    t_basic();
    t_bound();
    t_undef();
    t_length();
    t_wrap();
    t_strobe();
    t_wr_collide();
    t_len_collide();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule